// File: doc/BRIEF.md
# Mode-Controlled Bidirectional GPIO Port

This block is an eight-pin general-purpose I/O port. It holds two byte registers on a simple register bus: an output latch and a per-pin direction mask. A direction bit set to one makes that pin drive the latched value. A direction bit of zero leaves the pin as a high-impedance input. A read of the latch register returns a per-pin mix: the live pin level for input pins and the latched value for output pins.

The chip operating mode and an emulation-enable bit decide who owns the pins. In single-chip mode, and in special narrow expanded mode with emulation off, the port is GPIO and both registers answer on the bus. In wide expanded mode, in peripheral mode, and in special narrow expanded mode with emulation on, the registers leave the map. The pins then carry the low data byte supplied by an external bus controller, and that controller's drive-enable sets the pin direction. In these modes the incoming pin byte is always passed back to the bus side.

Register accesses are single-cycle and have no back-pressure. Reads are combinational, and writes take effect at the next rising edge. An access that this block does not claim raises a miss flag so that another target can take it. The mode and emulation inputs pass through a register, so any change takes effect one cycle later.

Top module: `gpio_modeport`

## Requirements
- R1: After reset both registers hold zero. Every pin_oe bit is 0, the direction register reads 0, and the latch register reads the pin_in value.
- R2: While mapped, a write at offset 0x07 loads the direction register from the next edge on, and a read at 0x07 returns it.
- R3: In GPIO modes, pin_oe[i] equals direction bit i and pin_out[i] equals latch bit i.
- R4: While mapped, a read at offset 0x05 returns, for each bit i, the latch bit when direction bit i is 1 and pin_in[i] when it is 0. A write at 0x05 loads the latch.
- R5: With op_mode 0 (single chip), or op_mode 1 (narrow expanded) and emu_en 0, an access at 0x05 or 0x07 has reg_miss 0.
- R6: With op_mode 2 (wide expanded) or 3 (peripheral), every access has reg_miss 1 and reg_rdata 0. Writes change neither register, which is seen once GPIO mode returns.
- R7: With op_mode 1 and emu_en 1, the registers are unmapped as in R6, and the pins carry the bus byte as in R8.
- R8: In bus-carrier modes, pin_out equals bus_lo_out and every pin_oe bit equals bus_lo_oe.
- R9: The effective mode is the op_mode/emu_en value sampled at the previous rising edge. A write in the cycle in which the mode inputs change is judged by the old mode. Mode changes never clear the registers.
- R10: bus_lo_in equals pin_in in every mode.
- R11: In any mode, an access at an offset other than 0x05 or 0x07 has reg_miss 1 and reg_rdata 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 2 | Operating mode: 0 single chip, 1 narrow expanded, 2 wide expanded, 3 peripheral |
| emu_en | input | 1 | Emulation enable; used in narrow expanded mode |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data; 0 on a miss or when idle |
| reg_miss | output | 1 | Access not claimed by this port |
| pin_in | input | 8 | Sampled pad levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables, 1 = drive |
| bus_lo_out | input | 8 | Low data byte to drive in bus-carrier modes |
| bus_lo_oe | input | 1 | Bus drive enable in bus-carrier modes |
| bus_lo_in | output | 8 | Pad levels returned to the bus side |

## Verification
Two things can fall in the same cycle: a register write and a change of the mode inputs. A write can arrive just as the port is handed to the bus, or as it is handed back. The random stimulus changes the mode in roughly one cycle out of eight while writes continue, and a directed case lines a latch write up with a switch to wide expanded mode. The bench's model decides each write by the mode it sampled at the previous edge. The written value must then come back after the port returns to GPIO mode, and writes issued during the bus-carrier mode must leave no trace.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    OPM_SINGLE = 2'd0,
    OPM_NARROW = 2'd1,
    OPM_WIDE   = 2'd2,
    OPM_PERIPH = 2'd3
  } opmode_e;

  // The port is GPIO only in single-chip mode or narrow mode without emulation.
  function automatic logic port_is_gpio(opmode_e m, logic emu);
    return (m == OPM_SINGLE) || ((m == OPM_NARROW) && !emu);
  endfunction

endpackage

// File: rtl/gpio_mode_ctl.sv
module gpio_mode_ctl
  import gpio_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       emu_i,
  output logic       gpio_act_o
);

  opmode_e mode_q;
  logic    emu_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= OPM_SINGLE;
      emu_q  <= 1'b0;
    end else begin
      mode_q <= opmode_e'(mode_i);
      emu_q  <= emu_i;
    end
  end

  assign gpio_act_o = port_is_gpio(mode_q, emu_q);

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile #(
  parameter int W        = 8,
  parameter int AW       = 8,
  parameter int DATA_OFS = 5,
  parameter int DIR_OFS  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gpio_act,
  input  logic          sel,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  rdata,
  output logic          miss,
  output logic [W-1:0]  data_q,
  output logic [W-1:0]  dir_q
);

  localparam logic [AW-1:0] DATA_A = AW'(DATA_OFS);
  localparam logic [AW-1:0] DIR_A  = AW'(DIR_OFS);

  logic hit_data, hit_dir;
  logic [W-1:0] data_view;

  assign hit_data = sel && gpio_act && (addr == DATA_A);
  assign hit_dir  = sel && gpio_act && (addr == DIR_A);
  assign miss     = sel && !(hit_data || hit_dir);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (we) begin
      if (hit_data) data_q <= wdata;
      if (hit_dir)  dir_q  <= wdata;
    end
  end

  // Output pins read back the latch, input pins read the pad level.
  assign data_view = (dir_q & data_q) | (~dir_q & pin_in);

  always_comb begin
    rdata = '0;
    if (hit_data)     rdata = data_view;
    else if (hit_dir) rdata = dir_q;
  end

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int W = 8
) (
  input  logic         gpio_act,
  input  logic [W-1:0] data_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] bus_out,
  input  logic         bus_oe,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pin_out[i] = gpio_act ? data_q[i] : bus_out[i];
    assign pin_oe[i]  = gpio_act ? dir_q[i]  : bus_oe;
  end

endmodule

// File: rtl/gpio_modeport.sv
module gpio_modeport #(
  parameter int W        = 8,
  parameter int AW       = 8,
  parameter int DATA_OFS = 5,
  parameter int DIR_OFS  = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    op_mode,
  input  logic          emu_en,
  input  logic          reg_sel,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  output logic          reg_miss,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  input  logic [W-1:0]  bus_lo_out,
  input  logic          bus_lo_oe,
  output logic [W-1:0]  bus_lo_in
);

  logic         gpio_act;
  logic [W-1:0] data_q, dir_q;

  gpio_mode_ctl u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (op_mode),
    .emu_i     (emu_en),
    .gpio_act_o(gpio_act)
  );

  gpio_regfile #(.W(W), .AW(AW), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .gpio_act(gpio_act),
    .sel     (reg_sel),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .pin_in  (pin_in),
    .rdata   (reg_rdata),
    .miss    (reg_miss),
    .data_q  (data_q),
    .dir_q   (dir_q)
  );

  gpio_pin_mux #(.W(W)) u_pins (
    .gpio_act(gpio_act),
    .data_q  (data_q),
    .dir_q   (dir_q),
    .bus_out (bus_lo_out),
    .bus_oe  (bus_lo_oe),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
  );

  assign bus_lo_in = pin_in;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   op_mode,
  input logic         emu_en,
  input logic         gpio_act,
  input logic [W-1:0] data_q,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] bus_lo_out,
  input logic         bus_lo_oe,
  input logic         reg_miss,
  input logic [W-1:0] reg_rdata
);

  // R6
  unmapped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gpio_act |=> ($stable(data_q) && $stable(dir_q)));

  // R3
  gpio_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_act |-> (pin_oe == dir_q && pin_out == data_q));

  // R8
  bus_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gpio_act |-> (pin_oe == {W{bus_lo_oe}} && pin_out == bus_lo_out));

  // R11
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_miss |-> (reg_rdata == '0));

  // R9
  mode_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (gpio_act == (($past(op_mode) == 2'd0) ||
                           ($past(op_mode) == 2'd1 && !$past(emu_en)))));

endmodule

bind gpio_modeport gpio_port_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_mode   (op_mode),
  .emu_en    (emu_en),
  .gpio_act  (gpio_act),
  .data_q    (data_q),
  .dir_q     (dir_q),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out),
  .bus_lo_out(bus_lo_out),
  .bus_lo_oe (bus_lo_oe),
  .reg_miss  (reg_miss),
  .reg_rdata (reg_rdata)
);

// File: tb/tb_gpio_modeport.sv
`timescale 1ns/1ps
module tb_gpio_modeport;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] op_mode = 2'd0;
  logic       emu_en = 1'b0;
  logic       reg_sel = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_addr = 8'd0, reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       reg_miss;
  logic [7:0] pin_in = 8'd0, pin_out, pin_oe;
  logic [7:0] bus_lo_out = 8'd0, bus_lo_in;
  logic       bus_lo_oe = 1'b0;

  int n_chk = 0, n_fail = 0;

  // model state
  logic [7:0] m_data = 8'd0, m_dir = 8'd0;
  logic [1:0] m_mode = 2'd0;
  logic       m_emu = 1'b0;

  always #2.5 clk = ~clk;

  gpio_modeport dut (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .emu_en(emu_en),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_miss(reg_miss), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .bus_lo_out(bus_lo_out), .bus_lo_oe(bus_lo_oe), .bus_lo_in(bus_lo_in)
  );

  function automatic bit f_gpio(logic [1:0] m, logic e);
    return (m == 2'd0) || (m == 2'd1 && !e);
  endfunction

  function automatic logic [7:0] f_rdata();
    if (!reg_sel || !f_gpio(m_mode, m_emu)) return 8'd0;
    if (reg_addr == 8'd5) return (m_dir & m_data) | (~m_dir & pin_in);
    if (reg_addr == 8'd7) return m_dir;
    return 8'd0;
  endfunction

  function automatic bit f_miss();
    if (!reg_sel) return 1'b0;
    return !(f_gpio(m_mode, m_emu) && (reg_addr == 8'd5 || reg_addr == 8'd7));
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    string rt;
    bit g;
    g = f_gpio(m_mode, m_emu);
    if (tag != "") rt = tag;
    else if (!reg_sel) rt = "R4";
    else if (reg_addr != 8'd5 && reg_addr != 8'd7) rt = "R11";
    else if (!g) rt = (m_mode == 2'd1) ? "R7" : "R6";
    else rt = (reg_addr == 8'd7) ? "R2" : "R4";
    chk(reg_rdata == f_rdata(), rt, reg_rdata, f_rdata());
    chk(reg_miss == f_miss(), (g && rt != "R11") ? "R5" : rt, reg_miss, f_miss());
    if (g) begin
      chk(pin_oe == m_dir && pin_out == m_data, "R3", {pin_oe, pin_out}, {m_dir, m_data});
    end else begin
      chk(pin_oe == {8{bus_lo_oe}} && pin_out == bus_lo_out, (m_mode == 2'd1) ? "R7" : "R8",
          {pin_oe, pin_out}, {{8{bus_lo_oe}}, bus_lo_out});
    end
    chk(bus_lo_in == pin_in, "R10", bus_lo_in, pin_in);
  endtask

  task automatic step(logic [1:0] m, logic e, logic s, logic w, logic [7:0] a, logic [7:0] wd,
                      logic [7:0] pi, logic [7:0] bo, logic boe, string tag);
    @(negedge clk);
    op_mode = m; emu_en = e; reg_sel = s; reg_we = w; reg_addr = a; reg_wdata = wd;
    pin_in = pi; bus_lo_out = bo; bus_lo_oe = boe;
    #1 check_all(tag);
    @(posedge clk);
    if (reg_sel && reg_we && f_gpio(m_mode, m_emu)) begin
      if (reg_addr == 8'd5) m_data = reg_wdata;
      else if (reg_addr == 8'd7) m_dir = reg_wdata;
    end
    m_mode = op_mode; m_emu = emu_en;
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    pin_in = 8'hA5;
    rst_n = 1'b1;
    // R1: reset state
    @(negedge clk);
    reg_sel = 1'b1; reg_we = 1'b0; reg_addr = 8'd5;
    #1;
    chk(pin_oe == 8'h00, "R1", pin_oe, 8'h00);
    chk(reg_rdata == 8'hA5, "R1", reg_rdata, 8'hA5);
    reg_addr = 8'd7;
    #1 chk(reg_rdata == 8'h00, "R1", reg_rdata, 8'h00);

    // directed: R2/R4 write and mixed readback
    step(2'd0, 1'b0, 1'b1, 1'b1, 8'd7, 8'hF0, 8'h5A, 8'h00, 1'b0, "R2");
    step(2'd0, 1'b0, 1'b1, 1'b1, 8'd5, 8'h3C, 8'h5A, 8'h00, 1'b0, "R4");
    step(2'd0, 1'b0, 1'b1, 1'b0, 8'd5, 8'h00, 8'h5A, 8'h00, 1'b0, "R4");
    // R9: write in the same cycle as the switch to wide mode is taken
    step(2'd2, 1'b0, 1'b1, 1'b1, 8'd5, 8'hC3, 8'h00, 8'h77, 1'b1, "R9");
    // R6: wide mode rejects writes
    step(2'd2, 1'b0, 1'b1, 1'b1, 8'd5, 8'h11, 8'h00, 8'h77, 1'b1, "R6");
    step(2'd3, 1'b0, 1'b1, 1'b1, 8'd7, 8'h22, 8'h00, 8'h66, 1'b0, "R6");
    // R7: narrow + emulation
    step(2'd1, 1'b1, 1'b1, 1'b1, 8'd7, 8'h33, 8'hFF, 8'h99, 1'b1, "R7");
    step(2'd1, 1'b1, 1'b1, 1'b0, 8'd5, 8'h00, 8'hFF, 8'h99, 1'b1, "R7");
    // back to narrow GPIO: values retained (R9)
    step(2'd1, 1'b0, 1'b1, 1'b0, 8'd7, 8'h00, 8'h0F, 8'h00, 1'b0, "R7");
    step(2'd1, 1'b0, 1'b1, 1'b0, 8'd7, 8'h00, 8'h0F, 8'h00, 1'b0, "R9");
    step(2'd1, 1'b0, 1'b1, 1'b0, 8'd5, 8'h00, 8'h0F, 8'h00, 1'b0, "R9");
    // R11: foreign offset
    step(2'd0, 1'b0, 1'b1, 1'b1, 8'd6, 8'hEE, 8'h0F, 8'h00, 1'b0, "R11");
    step(2'd0, 1'b0, 1'b1, 1'b0, 8'd5, 8'h00, 8'h0F, 8'h00, 1'b0, "R11");

    // constrained random with concurrent mode changes and writes
    for (int i = 0; i < 800; i++) begin
      logic [1:0] m;
      logic       e;
      logic [7:0] a;
      m = op_mode; e = emu_en;
      if ($urandom_range(7) == 0) begin
        m = 2'($urandom_range(3));
        e = 1'($urandom_range(1));
      end
      case ($urandom_range(4))
        0, 1:    a = 8'd5;
        2, 3:    a = 8'd7;
        default: a = 8'($urandom);
      endcase
      step(m, e, ($urandom_range(3) != 0), 1'($urandom_range(1)), a, 8'($urandom),
           8'($urandom), 8'($urandom), 1'($urandom_range(1)), "");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule